// File: doc/BRIEF.md
# Twisted-Ring Decimal Counter Chain

This block counts clock-synchronous count pulses in decimal. Each digit position (decade) keeps five state bits arranged as a shift ring. The complement of the last bit feeds back into the first bit, so the decade steps through ten distinct codes. A decade's codes always form a contiguous run of ones or zeros. That lets each of the ten decimal digits be decoded from exactly two state bits with a single two-input AND term, which keeps the decode shallow and glitch-free.

Decades are chained without rippled clocks. Every flop runs on the one system clock. A decade steps when the count pulse arrives while every lower decade shows nine. Each decade drives ten one-hot digit lines and a carry line, which is high while that decade shows nine. Each decade also drives a flag that is raised whenever its five bits hold one of the 22 codes that are not part of the ten-state cycle.

A preset input clears every ring, and so does the active-low reset. This is the normal way to start counting, because an arbitrary power-up code is not guaranteed to be legal. The default chain has three decades and counts 0 to 999.

Top module: `decade_ring_chain`

## Requirements
- R1: While rstN is low, and in the cycle after preset is sampled high, every decade holds state zero. In that state only digit line 0 of each decade is high and every carry bit is low.
- R2: Starting from zero, after k accepted count pulses (k = 1..9), decade 0 drives only digit line k. Digit line d of decade i is bit i*10+d of digitOneHot.
- R3: For every legal state, exactly one of a decade's ten digit lines is high.
- R4: carryOut[i] is high exactly while decade i shows digit 9.
- R5: The pulse accepted while a decade shows 9 returns that decade to digit 0 and drops its carry in the next cycle.
- R6: Decade i (i > 0) advances by one on a clock edge only when countEn is high and all decades below it show 9. It therefore steps once per ten steps of decade i-1.
- R7: With countEn low and preset low, no decade changes.
- R8: preset has priority over countEn: with both high, all decades clear to zero.
- R9: illegalState[i] is low whenever decade i holds one of its ten cycle codes. No count pulse can move a decade from a legal code to an illegal one.
- R10: The pulse accepted while every decade shows 9 returns the whole chain to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state updates on its rising edge |
| rstN | input | 1 | Asynchronous active-low reset, clears all rings |
| countEn | input | 1 | Count pulse, one step per cycle it is high |
| preset | input | 1 | Synchronous clear of all rings, overrides countEn |
| digitOneHot | output | NUM_DECADES*10 | One-hot decimal digit lines, ten per decade, decade 0 lowest |
| carryOut | output | NUM_DECADES | Per-decade carry, high while that decade shows 9 |
| illegalState | output | NUM_DECADES | Per-decade flag for a code outside the ten-state cycle |

## Verification
The assertions assume that countEn and preset are synchronous to clk. They also assume that every ring has been cleared by reset or preset before legality is relied on, because the one-hot property only holds on cycle codes. The stimulus changes inputs only on the falling clock edge, and it always begins with reset followed by a preset, so every decade stays inside its ten legal codes. The bench follows each output with a plain integer count and checks the full chain, including the wrap from 999 back to 000.

// File: rtl/decade_ring_pkg.sv
package decade_ring_pkg;
  // Bits per decade ring; a ring of N bits cycles through 2*N codes.
  localparam int RING_BITS = 5;
  localparam int DIGITS    = 2 * RING_BITS;

  // Per-decade strobes handed from control to datapath.
  typedef struct packed {
    logic clear;
    logic step;
  } ringStrobe_t;
endpackage

// File: rtl/decade_ring_ctrl.sv
module decade_ring_ctrl
  import decade_ring_pkg::*;
#(
  parameter int NUM_DECADES = 3
) (
  input  logic                               countEn,
  input  logic                               preset,
  input  logic [NUM_DECADES-1:0]             carryIn,
  output ringStrobe_t [NUM_DECADES-1:0]      strobes
);
  // Synchronous carry chain: enable ripples through decades showing nine.
  logic [NUM_DECADES:0] enableChain;

  assign enableChain[0] = countEn;

  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_chain
    assign enableChain[g+1] = enableChain[g] & carryIn[g];
    assign strobes[g].clear = preset;
    assign strobes[g].step  = enableChain[g] & ~preset;
  end
endmodule

// File: rtl/decade_ring_cell.sv
module decade_ring_cell
  import decade_ring_pkg::*;
#(
  parameter int RING_W = RING_BITS,
  localparam int DIG_W = 2 * RING_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  ringStrobe_t       strobe,
  output logic [DIG_W-1:0]  digits,
  output logic              carry,
  output logic              illegal
);
  // ringState[RING_W-1] is the first stage; shift runs towards bit 0.
  logic [RING_W-1:0] ringState;
  logic [RING_W-1:0] ringNext;
  logic [RING_W-1:0] stage;  // stage[j] = j-th stage counted from the input end

  assign ringNext = {~ringState[0], ringState[RING_W-1:1]};

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             ringState <= '0;
    else if (strobe.clear) ringState <= '0;
    else if (strobe.step)  ringState <= ringNext;
  end

  for (genvar j = 0; j < RING_W; j++) begin : g_stage
    assign stage[j] = ringState[RING_W-1-j];
  end

  // Two-input decode: every digit looks at one adjacent pair of stages.
  assign digits[0]      = ~stage[0] & ~stage[RING_W-1];
  assign digits[RING_W] =  stage[0] &  stage[RING_W-1];
  for (genvar k = 1; k < RING_W; k++) begin : g_decode
    assign digits[k]        =  stage[k-1] & ~stage[k];
    assign digits[RING_W+k] = ~stage[k-1] &  stage[k];
  end

  assign carry = digits[DIG_W-1];

  // Legal codes are runs with at most one boundary between adjacent stages.
  int unsigned edgeCount;
  always_comb begin
    edgeCount = 0;
    for (int j = 0; j < RING_W - 1; j++) begin
      if (stage[j] != stage[j+1]) edgeCount = edgeCount + 1;
    end
  end
  assign illegal = (edgeCount > 1);

  p_clear_r1: assert property (@(posedge clk) disable iff (!rstN)
    strobe.clear |=> (ringState == '0) && digits[0] && !carry);

  p_onehot_r3: assert property (@(posedge clk) disable iff (!rstN)
    !illegal |-> $onehot(digits));

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && strobe.step && carry) |=> (digits[0] && !carry));

  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.clear && !strobe.step) |=> $stable(ringState));

  p_legal_closed_r9: assert property (@(posedge clk) disable iff (!rstN)
    !illegal |=> !illegal);
endmodule

// File: rtl/decade_ring_datapath.sv
module decade_ring_datapath
  import decade_ring_pkg::*;
#(
  parameter int NUM_DECADES = 3
) (
  input  logic                              clk,
  input  logic                              rstN,
  input  ringStrobe_t [NUM_DECADES-1:0]     strobes,
  output logic [NUM_DECADES*DIGITS-1:0]     digitOneHot,
  output logic [NUM_DECADES-1:0]            carryOut,
  output logic [NUM_DECADES-1:0]            illegalState
);
  for (genvar g = 0; g < NUM_DECADES; g++) begin : g_decade
    decade_ring_cell #(.RING_W(RING_BITS)) u_cell (
      .clk     (clk),
      .rstN    (rstN),
      .strobe  (strobes[g]),
      .digits  (digitOneHot[g*DIGITS +: DIGITS]),
      .carry   (carryOut[g]),
      .illegal (illegalState[g])
    );
  end

  // Whole chain at 9..9 with a step on decade 0 must land on 0..0.
  p_full_wrap_r10: assert property (@(posedge clk) disable iff (!rstN)
    (&carryOut && strobes[0].step && !strobes[0].clear) |=> (carryOut == '0));

  for (genvar g = 1; g < NUM_DECADES; g++) begin : g_chain_chk
    p_step_needs_lower_nine_r6: assert property (@(posedge clk) disable iff (!rstN)
      (!strobes[g].clear && !carryOut[g-1]) |=> $stable(digitOneHot[g*DIGITS +: DIGITS]));
  end
endmodule

// File: rtl/decade_ring_chain.sv
module decade_ring_chain
  import decade_ring_pkg::*;
#(
  parameter int NUM_DECADES = 3,
  localparam int OUT_W = NUM_DECADES * DIGITS
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    countEn,
  input  logic                    preset,
  output logic [OUT_W-1:0]        digitOneHot,
  output logic [NUM_DECADES-1:0]  carryOut,
  output logic [NUM_DECADES-1:0]  illegalState
);
  ringStrobe_t [NUM_DECADES-1:0] strobes;

  decade_ring_ctrl #(.NUM_DECADES(NUM_DECADES)) u_ctrl (
    .countEn (countEn),
    .preset  (preset),
    .carryIn (carryOut),
    .strobes (strobes)
  );

  decade_ring_datapath #(.NUM_DECADES(NUM_DECADES)) u_datapath (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .digitOneHot  (digitOneHot),
    .carryOut     (carryOut),
    .illegalState (illegalState)
  );
endmodule

// File: tb/decade_ring_chain_bench.sv
module decade_ring_chain_bench;
  localparam int DEC  = 3;
  localparam int WRAP = 1000;
  localparam int NROW = 16;

  // Row: [11] countEn, [10] preset, [9:0] expected count after the edge.
  localparam logic [11:0] STIM [NROW] = '{
    {1'b1, 1'b0, 10'd1},  {1'b1, 1'b0, 10'd2},  {1'b0, 1'b0, 10'd2},
    {1'b1, 1'b0, 10'd3},  {1'b1, 1'b0, 10'd4},  {1'b1, 1'b0, 10'd5},
    {1'b1, 1'b0, 10'd6},  {1'b0, 1'b0, 10'd6},  {1'b1, 1'b0, 10'd7},
    {1'b1, 1'b0, 10'd8},  {1'b1, 1'b0, 10'd9},  {1'b1, 1'b0, 10'd10},
    {1'b1, 1'b0, 10'd11}, {1'b1, 1'b1, 10'd0},  {1'b0, 1'b0, 10'd0},
    {1'b1, 1'b0, 10'd1}
  };

  logic clk = 1'b0;
  logic rstN, countEn, preset;
  logic [DEC*10-1:0] digitOneHot;
  logic [DEC-1:0] carryOut, illegalState;

  int checks = 0;
  int fails = 0;
  int refCount = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  decade_ring_chain #(.NUM_DECADES(DEC)) u_decade_ring_chain (
    .clk(clk), .rstN(rstN), .countEn(countEn), .preset(preset),
    .digitOneHot(digitOneHot), .carryOut(carryOut), .illegalState(illegalState)
  );

  task automatic check(bit ok, string req, string what, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h (count %0d)", req, what, act, exp, refCount);
    end
  endtask

  task automatic checkAll(string tag);
    logic [DEC*10-1:0] expD = '0;
    logic [DEC-1:0] expC = '0;
    int v = refCount;
    for (int d = 0; d < DEC; d++) begin
      expD[d*10 + (v % 10)] = 1'b1;
      expC[d] = ((v % 10) == 9);
      v = v / 10;
    end
    check(digitOneHot[9:0] == expD[9:0], tag, "decade0 digits", 64'(digitOneHot[9:0]), 64'(expD[9:0]));
    check(digitOneHot[DEC*10-1:10] == expD[DEC*10-1:10], "R6", "upper digits",
          64'(digitOneHot[DEC*10-1:10]), 64'(expD[DEC*10-1:10]));
    check(carryOut == expC, "R4", "carry", 64'(carryOut), 64'(expC));
    for (int d = 0; d < DEC; d++) begin
      check($countones(digitOneHot[d*10 +: 10]) == 1, "R3", "one-hot",
            64'($countones(digitOneHot[d*10 +: 10])), 64'd1);
    end
    check(illegalState == '0, "R9", "illegal flag", 64'(illegalState), 64'd0);
  endtask

  task automatic apply(bit en, bit pre);
    countEn = en;
    preset  = pre;
    @(negedge clk);
    if (pre)     refCount = 0;
    else if (en) refCount = (refCount + 1) % WRAP;
  endtask

  initial begin
    rstN = 1'b0; countEn = 1'b0; preset = 1'b0;
    repeat (3) @(negedge clk);
    checkAll("R1");
    rstN = 1'b1;
    apply(1'b0, 1'b1);
    checkAll("R1");

    for (int r = 0; r < NROW; r++) begin
      string tag;
      apply(STIM[r][11], STIM[r][10]);
      if (STIM[r][10])                       tag = "R8";
      else if (!STIM[r][11])                 tag = "R7";
      else if (STIM[r][9:0] % 10 == 0)       tag = "R5";
      else                                   tag = "R2";
      check(refCount == int'(STIM[r][9:0]), tag, "table count", 64'(refCount), 64'(STIM[r][9:0]));
      checkAll(tag);
    end

    // Long run through every chain value up to 999.
    apply(1'b0, 1'b1);
    for (int n = 0; n < WRAP - 1; n++) begin
      apply(1'b1, 1'b0);
      checkAll((refCount % 10 == 0) ? "R5" : "R2");
    end
    check(carryOut == '1, "R4", "all carries at 999", 64'(carryOut), 64'h7);
    apply(1'b0, 1'b0);
    checkAll("R7");
    apply(1'b1, 1'b0);
    check(refCount == 0, "R10", "wrap model", 64'(refCount), 64'd0);
    checkAll("R10");

    // Asynchronous reset in the middle of counting.
    repeat (37) apply(1'b1, 1'b0);
    checkAll("R2");
    countEn = 1'b0;
    #1 rstN = 1'b0;
    @(negedge clk);
    refCount = 0;
    checkAll("R1");
    rstN = 1'b1;
    apply(1'b1, 1'b1);
    checkAll("R8");

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule